// File: doc/BRIEF.md
# Slow-Clock Timer with CPU-Side Synchronisation

This block is a small up-counter that runs entirely on a slow, free-running timer clock, such as a watch crystal, while software reads and writes it from a much faster CPU clock. Two compare channels and a wrap-around event each raise a flag in the CPU domain. Each flag has an enable bit, and a global interrupt enable gates all three requests. A compare output pin toggles on compare-channel-A matches. It is driven straight from the timer clock.

No multi-bit value ever crosses the clock boundary unguarded. Compare and control writes are held in CPU-side staging registers. They are handed over with a toggle handshake, and a busy bit stays set until the timer domain has taken the value. The readable count is a CPU-side copy, re-captured after every timer-clock rising edge. Timer events travel as toggles through synchronisers and set their flags a fixed number of CPU cycles after the event.

Register addresses on the 3-bit bus: 0 count (read only), 1 compare A, 2 compare B, 3 control (bit 0 run, bit 1 pin toggle enable), 4 interrupt enable, 5 flags, 6 busy (bit 0 compare A, bit 1 compare B, bit 2 control), 7 spare (reads 0).

Top module: `slowclk_timer`

## Requirements
- R1: After reset every register address reads 0, all three interrupt requests are low and the compare pin is low.
- R2: The count read at address 0 changes on the (SYNC_N+1)-th CPU rising edge after a timer rising edge and holds its old value before that edge. Its value equals the number of timer edges counted, modulo 2^CNT_W.
- R3: The counter advances by one on a timer edge only while control bit 0 (run) is 1 in the timer domain. While stopped, the count stays constant and no event is raised.
- R4: A write to address 1, 2 or 3 sets that register's busy bit (bits 0, 1, 2 at address 6) on the next CPU cycle. The bit clears on the SYNC_N-th CPU edge after the (SYNC_N+1)-th timer edge that follows the write.
- R5: A write to a staged register whose busy bit is set is dropped. The register keeps and reads back the earlier value.
- R6: On a counting timer edge, the compare-A flag (flag bit 1) sets if the count before the edge equals compare A. The compare-B flag (bit 2) sets if it equals compare B. The overflow flag (bit 0) sets if it equals the all-ones maximum. Each flag becomes readable on the (SYNC_N+1)-th CPU edge after that timer edge.
- R7: Writing 1 to a bit at address 5 clears that flag. Writing 0 leaves it unchanged.
- R8: The interrupt enable register holds compare-B enable in bit 2, compare-A enable in bit 1 and overflow enable in bit 0. Bits 7 to 3 read as zero.
- R9: Each interrupt request is high exactly when its flag, its enable bit and the global enable input are all 1.
- R10: The compare pin toggles on the timer edge of a compare-A event when control bit 1 is 1, with no CPU-clock delay. Otherwise it holds its value.
- R11: Writes to addresses 0, 6 and 7 have no effect on any readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU / bus clock |
| cpu_rst_n | input | 1 | Asynchronous active-low reset, CPU domain |
| tmr_clk | input | 1 | Slow timer clock |
| tmr_rst_n | input | 1 | Asynchronous active-low reset, timer domain |
| bus_wr | input | 1 | Write strobe, sampled on cpu_clk |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| gie | input | 1 | Global interrupt enable |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmpa | output | 1 | Compare-A interrupt request |
| irq_cmpb | output | 1 | Compare-B interrupt request |
| cmp_pin | output | 1 | Compare output pin, timer domain |

## Verification
The bench builds the block with CNT_W = 4 and SYNC_N = 2. A full counter lap is then 16 timer edges, so every compare-A value from 0 to 15 can be swept, each paired with a different compare-B value, and the overflow is crossed on every lap. The bench drives each timer edge itself, half-way between CPU edges. This lets it check the two-cycle-stale and third-cycle-fresh behaviour of the count and the flags exactly, along with the busy-bit release cycle and the pin change on the timer edge itself.

// File: rtl/slt_pkg.sv
`timescale 1ns/1ps
package slt_pkg;
   localparam int DATA_W   = 8;
   localparam int N_EV     = 3;
   localparam int EV_OVF   = 0;
   localparam int EV_CMPA  = 1;
   localparam int EV_CMPB  = 2;
   localparam int N_CMP    = 2;
   localparam int CTRL_W   = 2;
   localparam int CTRL_RUN = 0;
   localparam int CTRL_PIN = 1;

   typedef enum logic [2:0] {
      RA_COUNT = 3'd0,
      RA_CMPA  = 3'd1,
      RA_CMPB  = 3'd2,
      RA_CTRL  = 3'd3,
      RA_MASK  = 3'd4,
      RA_FLAG  = 3'd5,
      RA_BUSY  = 3'd6,
      RA_SPARE = 3'd7
   } reg_addr_e;
endpackage

// File: rtl/slt_sync.sv
`timescale 1ns/1ps
module slt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("slt_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/slt_stage.sv
`timescale 1ns/1ps
module slt_stage #(
   parameter int W      = 8,
   parameter int SYNC_N = 2
) (
   input  logic         cpu_clk,
   input  logic         cpu_rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] hold_o,
   output logic         busy_o,
   input  logic         tmr_clk,
   input  logic         tmr_rst_n,
   output logic [W-1:0] tval_o
);
   logic         req_q;
   logic [W-1:0] hold_q;
   logic         ack_s;
   logic         req_s;
   logic         last_q;
   logic [W-1:0] tval_q;

   // CPU side: capture into the hold register and flip the request toggle
   always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
      if (!cpu_rst_n) begin
         req_q  <= 1'b0;
         hold_q <= '0;
      end else if (wr_en && !busy_o) begin
         req_q  <= ~req_q;
         hold_q <= wr_data;
      end
   end

   slt_sync #(.STAGES(SYNC_N)) u_ack_sync (
      .clk(cpu_clk), .rst_n(cpu_rst_n), .d(last_q), .q(ack_s));

   assign busy_o = req_q ^ ack_s;
   assign hold_o = hold_q;

   // Timer side: take the held value once the request toggle arrives
   slt_sync #(.STAGES(SYNC_N)) u_req_sync (
      .clk(tmr_clk), .rst_n(tmr_rst_n), .d(req_q), .q(req_s));

   always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
      if (!tmr_rst_n) begin
         last_q <= 1'b0;
         tval_q <= '0;
      end else if (req_s != last_q) begin
         last_q <= req_s;
         tval_q <= hold_q;
      end
   end

   assign tval_o = tval_q;

   // R4
   busy_rise_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
      $rose(busy_o) |-> $past(wr_en));

   // R5
   hold_stable_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
      (busy_o && $past(busy_o)) |-> $stable(hold_q));
endmodule

// File: rtl/slt_evt.sv
`timescale 1ns/1ps
module slt_evt #(
   parameter int SYNC_N = 2
) (
   input  logic tmr_clk,
   input  logic tmr_rst_n,
   input  logic ev_i,
   input  logic cpu_clk,
   input  logic cpu_rst_n,
   output logic pulse_o
);
   logic tgl_q;
   logic tgl_s;
   logic prev_q;

   always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
      if (!tmr_rst_n) tgl_q <= 1'b0;
      else if (ev_i)  tgl_q <= ~tgl_q;
   end

   slt_sync #(.STAGES(SYNC_N)) u_tgl_sync (
      .clk(cpu_clk), .rst_n(cpu_rst_n), .d(tgl_q), .q(tgl_s));

   always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
      if (!cpu_rst_n) prev_q <= 1'b0;
      else            prev_q <= tgl_s;
   end

   assign pulse_o = tgl_s ^ prev_q;
endmodule

// File: rtl/slt_core.sv
`timescale 1ns/1ps
module slt_core
   import slt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic                        tmr_clk,
   input  logic                        tmr_rst_n,
   input  logic                        run_i,
   input  logic                        pin_en_i,
   input  logic [N_CMP-1:0][CNT_W-1:0] cmp_i,
   output logic [CNT_W-1:0]            cnt_o,
   output logic [N_EV-1:0]             ev_o,
   output logic                        pin_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             pin_q;

   assign ev_o[EV_OVF] = run_i && (cnt_q == CNT_MAX);

   generate
      for (genvar i = 0; i < N_CMP; i++) begin : g_match
         assign ev_o[EV_CMPA+i] = run_i && (cnt_q == cmp_i[i]);
      end
   endgenerate

   always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
      if (!tmr_rst_n) begin
         cnt_q <= '0;
         pin_q <= 1'b0;
      end else begin
         if (run_i)                  cnt_q <= cnt_q + CNT_W'(1);
         if (pin_en_i && ev_o[EV_CMPA]) pin_q <= ~pin_q;
      end
   end

   assign cnt_o = cnt_q;
   assign pin_o = pin_q;

   // R3
   cnt_step_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
      (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));

   // R10
   pin_toggle_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
      (pin_q != $past(pin_q)) |-> $past(pin_en_i && ev_o[EV_CMPA]));
endmodule

// File: rtl/slowclk_timer.sv
`timescale 1ns/1ps
module slowclk_timer
   import slt_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int SYNC_N = 2
) (
   input  logic              cpu_clk,
   input  logic              cpu_rst_n,
   input  logic              tmr_clk,
   input  logic              tmr_rst_n,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              gie,
   output logic              irq_ovf,
   output logic              irq_cmpa,
   output logic              irq_cmpb,
   output logic              cmp_pin
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_width
         $error("slowclk_timer: CNT_W must lie in 2..DATA_W");
      end
   endgenerate

   logic [N_CMP-1:0][CNT_W-1:0] cmp_hold;
   logic [N_CMP-1:0][CNT_W-1:0] cmp_tmr;
   logic [N_CMP-1:0]            cmp_busy;
   logic [CTRL_W-1:0]           ctrl_hold;
   logic [CTRL_W-1:0]           ctrl_tmr;
   logic                        ctrl_busy;
   logic [CNT_W-1:0]            cnt_tmr;
   logic [CNT_W-1:0]            rd_cnt_q;
   logic                        cap_pulse;
   logic [N_EV-1:0]             ev_tmr;
   logic [N_EV-1:0]             ev_set;
   logic [N_EV-1:0]             ev_clr;
   logic [N_EV-1:0]             flag_q;
   logic [N_EV-1:0]             mask_q;
   logic [N_EV-1:0]             irq_vec;

   // staged compare registers
   generate
      for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
         localparam logic [2:0] MY_ADDR = (i == 0) ? RA_CMPA : RA_CMPB;
         slt_stage #(.W(CNT_W), .SYNC_N(SYNC_N)) u_stage (
            .cpu_clk  (cpu_clk),
            .cpu_rst_n(cpu_rst_n),
            .wr_en    (bus_wr && (bus_addr == MY_ADDR)),
            .wr_data  (bus_wdata[CNT_W-1:0]),
            .hold_o   (cmp_hold[i]),
            .busy_o   (cmp_busy[i]),
            .tmr_clk  (tmr_clk),
            .tmr_rst_n(tmr_rst_n),
            .tval_o   (cmp_tmr[i]));
      end
   endgenerate

   // staged control register
   slt_stage #(.W(CTRL_W), .SYNC_N(SYNC_N)) u_ctrl_stage (
      .cpu_clk  (cpu_clk),
      .cpu_rst_n(cpu_rst_n),
      .wr_en    (bus_wr && (bus_addr == RA_CTRL)),
      .wr_data  (bus_wdata[CTRL_W-1:0]),
      .hold_o   (ctrl_hold),
      .busy_o   (ctrl_busy),
      .tmr_clk  (tmr_clk),
      .tmr_rst_n(tmr_rst_n),
      .tval_o   (ctrl_tmr));

   slt_core #(.CNT_W(CNT_W)) u_core (
      .tmr_clk  (tmr_clk),
      .tmr_rst_n(tmr_rst_n),
      .run_i    (ctrl_tmr[CTRL_RUN]),
      .pin_en_i (ctrl_tmr[CTRL_PIN]),
      .cmp_i    (cmp_tmr),
      .cnt_o    (cnt_tmr),
      .ev_o     (ev_tmr),
      .pin_o    (cmp_pin));

   // count snapshot: re-captured after every timer edge
   slt_evt #(.SYNC_N(SYNC_N)) u_cnt_evt (
      .tmr_clk  (tmr_clk),
      .tmr_rst_n(tmr_rst_n),
      .ev_i     (1'b1),
      .cpu_clk  (cpu_clk),
      .cpu_rst_n(cpu_rst_n),
      .pulse_o  (cap_pulse));

   always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
      if (!cpu_rst_n)     rd_cnt_q <= '0;
      else if (cap_pulse) rd_cnt_q <= cnt_tmr;
   end

   // event transport into the CPU domain
   generate
      for (genvar e = 0; e < N_EV; e++) begin : g_ev
         slt_evt #(.SYNC_N(SYNC_N)) u_evt (
            .tmr_clk  (tmr_clk),
            .tmr_rst_n(tmr_rst_n),
            .ev_i     (ev_tmr[e]),
            .cpu_clk  (cpu_clk),
            .cpu_rst_n(cpu_rst_n),
            .pulse_o  (ev_set[e]));
      end
   endgenerate

   assign ev_clr = (bus_wr && (bus_addr == RA_FLAG)) ? bus_wdata[N_EV-1:0] : '0;

   always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
      if (!cpu_rst_n) begin
         flag_q <= '0;
         mask_q <= '0;
      end else begin
         flag_q <= (flag_q & ~ev_clr) | ev_set;
         if (bus_wr && (bus_addr == RA_MASK)) mask_q <= bus_wdata[N_EV-1:0];
      end
   end

   assign irq_vec  = gie ? (flag_q & mask_q) : '0;
   assign irq_ovf  = irq_vec[EV_OVF];
   assign irq_cmpa = irq_vec[EV_CMPA];
   assign irq_cmpb = irq_vec[EV_CMPB];

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_COUNT: bus_rdata[CNT_W-1:0]  = rd_cnt_q;
         RA_CMPA:  bus_rdata[CNT_W-1:0]  = cmp_hold[0];
         RA_CMPB:  bus_rdata[CNT_W-1:0]  = cmp_hold[1];
         RA_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_hold;
         RA_MASK:  bus_rdata[N_EV-1:0]   = mask_q;
         RA_FLAG:  bus_rdata[N_EV-1:0]   = flag_q;
         RA_BUSY:  bus_rdata[2:0]        = {ctrl_busy, cmp_busy};
         default:  bus_rdata = '0;
      endcase
   end

   // R9
   irq_gate_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
      (irq_ovf || irq_cmpa || irq_cmpb) |-> gie);
endmodule

// File: tb/slowclk_timer_bench.sv
`timescale 1ns/1ps
module slowclk_timer_bench;
   import slt_pkg::*;

   localparam int CW   = 4;
   localparam int CMAX = (1 << CW) - 1;

   logic       cpu_clk = 1'b0;
   logic       cpu_rst_n = 1'b0;
   logic       tmr_clk = 1'b0;
   logic       tmr_rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       gie = 1'b0;
   logic       irq_ovf, irq_cmpa, irq_cmpb, cmp_pin;

   int n_chk = 0;
   int n_fail = 0;

   slowclk_timer #(.CNT_W(CW), .SYNC_N(2)) u_slowclk_timer (
      .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .gie(gie), .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb),
      .cmp_pin(cmp_pin));

   always #2.5 cpu_clk = ~cpu_clk;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge cpu_clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge cpu_clk);
      bus_wr = 1'b0;
   endtask

   task automatic cpu_rd(input logic [2:0] a, output int v);
      bus_addr = a;
      #0.5;
      v = int'(bus_rdata);
   endtask

   task automatic tmr_rise();
      @(negedge cpu_clk);
      tmr_clk = 1'b1;
   endtask

   task automatic tmr_fall();
      repeat (4) @(negedge cpu_clk);
      tmr_clk = 1'b0;
      repeat (4) @(negedge cpu_clk);
   endtask

   task automatic tmr_pulse();
      tmr_rise();
      tmr_fall();
   endtask

   task automatic commit(input logic [2:0] a, input logic [7:0] d);
      int b;
      cpu_wr(a, d);
      b = 1;
      for (int k = 0; k < 8 && b != 0; k++) begin
         tmr_pulse();
         cpu_rd(RA_BUSY, b);
      end
      check("R4 busy clears after handover", b, 0);
   endtask

   initial begin
      repeat (150000) @(posedge cpu_clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int v, c, p, pre, f, expf, expp, vb;
      repeat (3) @(negedge cpu_clk);
      cpu_rst_n = 1'b1; tmr_rst_n = 1'b1;
      repeat (2) @(negedge cpu_clk);

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         cpu_rd(3'(a), v);
         check("R1 register reads zero after reset", v, 0);
      end
      check("R1 irq low after reset", {irq_ovf, irq_cmpa, irq_cmpb}, 0);
      check("R1 pin low after reset", cmp_pin, 0);

      // R4 busy timing, R5 dropped write
      cpu_wr(RA_CMPA, 8'd5);
      cpu_rd(RA_BUSY, v);
      check("R4 busy set after write", v, 1);
      cpu_wr(RA_CMPA, 8'd9);
      tmr_pulse(); tmr_pulse();
      cpu_rd(RA_BUSY, v);
      check("R4 busy held before third timer edge", v, 1);
      tmr_rise();
      @(negedge cpu_clk);
      cpu_rd(RA_BUSY, v);
      check("R4 busy still set one cpu edge after third timer edge", v, 1);
      @(negedge cpu_clk);
      cpu_rd(RA_BUSY, v);
      check("R4 busy clear two cpu edges after third timer edge", v, 0);
      tmr_fall();
      cpu_rd(RA_CMPA, v);
      check("R5 write during busy dropped", v, 5);

      // R11 writes to read-only addresses
      cpu_wr(RA_COUNT, 8'hAA);
      cpu_wr(RA_BUSY, 8'h07);
      cpu_wr(RA_SPARE, 8'hFF);
      cpu_rd(RA_COUNT, v); check("R11 count write ignored", v, 0);
      cpu_rd(RA_BUSY, v);  check("R11 busy write ignored", v, 0);
      cpu_rd(RA_SPARE, v); check("R11 spare reads zero", v, 0);

      // R8 enable register layout
      cpu_wr(RA_MASK, 8'hFF);
      cpu_rd(RA_MASK, v);
      check("R8 enable upper bits read zero", v, 8'h07);
      cpu_wr(RA_MASK, 8'h00);

      // sweep every compare-A position
      for (int va = 0; va <= CMAX; va++) begin
         vb = (va * 7 + 3) % (CMAX + 1);
         commit(RA_CTRL, 8'd2);
         commit(RA_CMPA, 8'(va));
         commit(RA_CMPB, 8'(vb));
         cpu_wr(RA_FLAG, 8'h07);
         cpu_rd(RA_FLAG, f);
         check("R7 flags cleared by writing ones", f, 0);
         cpu_rd(RA_COUNT, c);
         p = cmp_pin;
         tmr_pulse(); tmr_pulse();
         cpu_rd(RA_COUNT, v);
         check("R3 stopped counter holds", v, c);
         cpu_rd(RA_FLAG, f);
         check("R3 stopped counter raises no event", f, 0);
         commit(RA_CTRL, 8'd3);
         cpu_rd(RA_COUNT, v);
         check("R3 no count before run reaches timer domain", v, c);
         for (int k = 0; k <= CMAX; k++) begin
            pre  = c;
            expf = ((pre == vb) ? 4 : 0) | ((pre == va) ? 2 : 0) | ((pre == CMAX) ? 1 : 0);
            expp = p ^ ((pre == va) ? 1 : 0);
            tmr_rise();
            #0.5;
            check("R10 pin follows compare-A on timer edge", cmp_pin, expp);
            @(negedge cpu_clk);
            @(negedge cpu_clk);
            cpu_rd(RA_COUNT, v);
            check("R2 count stale two cpu edges after timer edge", v, pre);
            cpu_rd(RA_FLAG, f);
            check("R6 flags not yet visible", f, 0);
            @(negedge cpu_clk);
            cpu_rd(RA_COUNT, v);
            check("R2 count fresh on third cpu edge", v, (pre + 1) % (CMAX + 1));
            cpu_rd(RA_FLAG, f);
            check("R6 flags on third cpu edge", f, expf);
            p = expp;
            c = (pre + 1) % (CMAX + 1);
            tmr_fall();
            if (expf != 0) begin
               cpu_wr(RA_FLAG, 8'h00);
               cpu_rd(RA_FLAG, f);
               check("R7 writing zero keeps flags", f, expf);
            end
            cpu_wr(RA_FLAG, 8'h07);
            cpu_rd(RA_FLAG, f);
            check("R7 writing ones clears flags", f, 0);
         end
      end

      // R9 request gating, R10 pin disabled
      commit(RA_CTRL, 8'd0);
      cpu_rd(RA_COUNT, c);
      commit(RA_CMPA, 8'(c));
      commit(RA_CMPB, 8'(c));
      cpu_wr(RA_FLAG, 8'h07);
      p = cmp_pin;
      commit(RA_CTRL, 8'd1);
      tmr_rise();
      #0.5;
      check("R10 pin holds with toggle disabled", cmp_pin, p);
      repeat (3) @(negedge cpu_clk);
      expf = 6 | ((c == CMAX) ? 1 : 0);
      cpu_rd(RA_FLAG, f);
      check("R6 both compares match same count", f, expf);
      tmr_fall();
      gie = 1'b1;
      cpu_wr(RA_MASK, 8'h00);
      check("R9 no request with enables clear", {irq_cmpb, irq_cmpa, irq_ovf}, 0);
      cpu_wr(RA_MASK, 8'h02);
      check("R9 only compare-A request", {irq_cmpb, irq_cmpa, irq_ovf}, 2);
      gie = 1'b0;
      #0.5;
      check("R9 global enable gates requests", {irq_cmpb, irq_cmpa, irq_ovf}, 0);
      gie = 1'b1;
      cpu_wr(RA_MASK, 8'h07);
      check("R9 all enabled requests", {irq_cmpb, irq_cmpa, irq_ovf}, expf);
      cpu_wr(RA_FLAG, 8'h02);
      check("R9 request drops with cleared flag", {irq_cmpb, irq_cmpa, irq_ovf}, expf & 5);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule